// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address by walking a two-level table tree held in memory. A root register holds the page-aligned physical address of a 4 KiB directory page. The directory page holds 1024 four-byte entries. A translation request first reads one directory entry. That entry may map a 4 MiB page directly. Otherwise it points to a second-level table of 1024 four-byte entries, each of which maps a 4 KiB page. In that case the walker reads one table entry as well. The result returns the physical address, a large-page flag and the combined write and user permissions, or it reports a page fault.

Memory is reached through a single word read port. The request side uses a valid/ready handshake and the response side uses a valid strobe. Only one walk runs at a time, and `busy` tells the requester that new requests are not being taken. The walk is a state machine with six states:

- IDLE: accepts a request, then moves to DIR_REQ.
- DIR_REQ: presents the directory read and moves to DIR_WAIT when the read is accepted.
- DIR_WAIT: waits for the directory data. It moves to DONE on a non-present entry or a large-page entry, and to TBL_REQ otherwise.
- TBL_REQ: presents the table read and moves to TBL_WAIT when the read is accepted.
- TBL_WAIT: moves to DONE when the table data arrives.
- DONE: drives the response for one cycle and returns to IDLE.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `rsp_valid` and `mem_req_valid` are 0 and the root register is 0.
- R2: The first read of a walk goes to address {root[31:12], va[31:22], 2'b00}, using the root value held when the request was accepted.
- R3: Entry bit 0 is the present flag and bit 7 the large-page flag. A present directory entry with bit 7 clear causes a second read at {pde[31:12], va[21:12], 2'b00}.
- R4: When the table entry has bit 0 set, the response gives `rsp_pa` = {pte[31:12], va[11:0]}, with `rsp_large` = 0 and `rsp_fault` = 0.
- R5: A directory entry with bits 0 and 7 both set ends the walk after one read, with `rsp_pa` = {pde[31:22], va[21:0]} and `rsp_large` = 1.
- R6: A directory entry with bit 0 clear ends the walk after one read, with `rsp_fault` = 1 and `rsp_pa`, `rsp_large`, `rsp_writable`, `rsp_user` all 0.
- R7: A table entry with bit 0 clear ends the walk with `rsp_fault` = 1 and `rsp_pa`, `rsp_large`, `rsp_writable`, `rsp_user` all 0.
- R8: Bit 1 is writable and bit 2 is user. For a 4 KiB page each result flag is the AND of that bit in both entries. For a large page each flag is the directory entry's bit.
- R9: A memory request holds its valid and a stable address until `mem_req_ready` is seen. The walker never has more than one read outstanding. It issues no read while idle.
- R10: `busy` rises the cycle after a request is accepted and stays high until the response. A `req_valid` seen while busy is ignored, together with its address.
- R11: `rsp_valid` is a one-cycle pulse. The walker is idle (`busy` = 0) in the next cycle.
- R12: A root write made during a walk does not change that walk's directory address. It applies from the next request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_wr_en | input | 1 | Write strobe for the root register |
| root_wr_data | input | 32 | New root value; bits 11:0 are ignored |
| req_valid | input | 1 | Translation request, taken when `busy` is 0 |
| req_va | input | 32 | Virtual address to translate |
| busy | output | 1 | A walk is in progress |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | Page fault at either level |
| rsp_pa | output | 32 | Translated physical address |
| rsp_large | output | 1 | Translation came from a 4 MiB page |
| rsp_writable | output | 1 | Combined write permission |
| rsp_user | output | 1 | Combined user permission |
| mem_req_valid | output | 1 | Read request to memory |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 32 | Entry read from memory |

## Verification
The hardest case to reach is a root write or a new request that arrives while the walk is stalled at the memory port. Ports alone do not show which root value or which virtual address the walk has latched. The bench's memory model randomises `mem_req_ready` and the response latency, so reads stall in both request states. Directed walks write a new root right after acceptance, and hold `req_valid` high with a different address through a whole walk. The bench then compares the exact read addresses with those built from the values present at acceptance.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int BIT_PRESENT = 0;
    localparam int BIT_WRITE   = 1;
    localparam int BIT_USER    = 2;
    localparam int BIT_LARGE   = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_TBL_REQ,
        ST_TBL_WAIT,
        ST_DONE
    } walk_state_t;
endpackage

// File: rtl/ptw_root_reg.sv
module ptw_root_reg #(
    parameter int AW    = 32,
    parameter int OFF_W = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_data,
    input  logic          capture,
    output logic [AW-1:0] root_snap
);
    logic [AW-OFF_W-1:0] root_q;
    logic [AW-OFF_W-1:0] snap_q;
    logic                unused_low;

    assign unused_low = ^wr_data[OFF_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            root_q <= '0;
            snap_q <= '0;
        end else begin
            if (wr_en)
                root_q <= wr_data[AW-1:OFF_W];
            if (capture)
                snap_q <= root_q;
        end
    end

    assign root_snap = {snap_q, {OFF_W{1'b0}}};
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int IDX_W = 10,
    localparam int OFF_W = IDX_W + 2,
    localparam int AW    = 3 * IDX_W + 2
) (
    input  logic [AW-1:0] root,
    input  logic [AW-1:0] va,
    input  logic [AW-1:0] pde,
    input  logic [AW-1:0] pte,
    output logic [AW-1:0] dir_addr,
    output logic [AW-1:0] tbl_addr,
    output logic [AW-1:0] pa_small,
    output logic [AW-1:0] pa_large
);
    logic unused_flags;

    assign unused_flags = ^{root[OFF_W-1:0], pde[OFF_W-1:0], pte[OFF_W-1:0]};

    // Each entry is 4 bytes, so the index is shifted left by two bits.
    assign dir_addr = {root[AW-1:OFF_W], va[AW-1 -: IDX_W], 2'b00};
    assign tbl_addr = {pde[AW-1:OFF_W], va[OFF_W+IDX_W-1:OFF_W], 2'b00};
    assign pa_small = {pte[AW-1:OFF_W], va[OFF_W-1:0]};
    assign pa_large = {pde[AW-1:OFF_W+IDX_W], va[OFF_W+IDX_W-1:0]};
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
    import ptw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          mem_req_ready,
    input  logic          mem_rsp_valid,
    input  logic [AW-1:0] mem_rsp_data,
    output logic          accept,
    output logic          busy,
    output logic          mem_req_valid,
    output logic          use_tbl,
    output logic [AW-1:0] pde_q,
    output logic [AW-1:0] pte_q,
    output logic          rsp_valid,
    output logic          rsp_fault,
    output logic          rsp_large,
    output logic          rsp_wr,
    output logic          rsp_usr
);
    walk_state_t state, state_n;
    logic        fault_q;
    logic        large_q;
    logic        pde_hit;
    logic        pte_hit;

    assign pde_hit = (state == ST_DIR_WAIT) && mem_rsp_valid;
    assign pte_hit = (state == ST_TBL_WAIT) && mem_rsp_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pde_q   <= '0;
            pte_q   <= '0;
            fault_q <= 1'b0;
            large_q <= 1'b0;
        end else begin
            state <= state_n;
            if (pde_hit) begin
                pde_q   <= mem_rsp_data;
                fault_q <= !mem_rsp_data[BIT_PRESENT];
                large_q <= mem_rsp_data[BIT_PRESENT] && mem_rsp_data[BIT_LARGE];
            end
            if (pte_hit) begin
                pte_q   <= mem_rsp_data;
                fault_q <= !mem_rsp_data[BIT_PRESENT];
            end
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:     if (req_valid) state_n = ST_DIR_REQ;
            ST_DIR_REQ:  if (mem_req_ready) state_n = ST_DIR_WAIT;
            ST_DIR_WAIT: if (mem_rsp_valid) begin
                             if (!mem_rsp_data[BIT_PRESENT] || mem_rsp_data[BIT_LARGE])
                                 state_n = ST_DONE;
                             else
                                 state_n = ST_TBL_REQ;
                         end
            ST_TBL_REQ:  if (mem_req_ready) state_n = ST_TBL_WAIT;
            ST_TBL_WAIT: if (mem_rsp_valid) state_n = ST_DONE;
            ST_DONE:     state_n = ST_IDLE;
            default:     state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        busy          = (state != ST_IDLE);
        accept        = (state == ST_IDLE) && req_valid;
        mem_req_valid = (state == ST_DIR_REQ) || (state == ST_TBL_REQ);
        use_tbl       = (state == ST_TBL_REQ);
        rsp_valid     = (state == ST_DONE);
        rsp_fault     = rsp_valid && fault_q;
        rsp_large     = rsp_valid && !fault_q && large_q;
        rsp_wr        = 1'b0;
        rsp_usr       = 1'b0;
        if (rsp_valid && !fault_q) begin
            if (large_q) begin
                rsp_wr  = pde_q[BIT_WRITE];
                rsp_usr = pde_q[BIT_USER];
            end else begin
                rsp_wr  = pde_q[BIT_WRITE] & pte_q[BIT_WRITE];
                rsp_usr = pde_q[BIT_USER] & pte_q[BIT_USER];
            end
        end
    end

    // R10
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R11
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && !busy));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid);

    // R6
    fault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (!rsp_large && !rsp_wr && !rsp_usr));
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
    parameter int IDX_W = 10,
    localparam int AW    = 3 * IDX_W + 2,
    localparam int OFF_W = IDX_W + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          root_wr_en,
    input  logic [AW-1:0] root_wr_data,
    input  logic          req_valid,
    input  logic [AW-1:0] req_va,
    output logic          busy,
    output logic          rsp_valid,
    output logic          rsp_fault,
    output logic [AW-1:0] rsp_pa,
    output logic          rsp_large,
    output logic          rsp_writable,
    output logic          rsp_user,
    output logic          mem_req_valid,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_req_ready,
    input  logic          mem_rsp_valid,
    input  logic [AW-1:0] mem_rsp_data
);
    logic          accept;
    logic          use_tbl;
    logic [AW-1:0] va_q;
    logic [AW-1:0] root_snap;
    logic [AW-1:0] pde_q, pte_q;
    logic [AW-1:0] dir_addr, tbl_addr, pa_small, pa_large;

    always_ff @(posedge clk) begin
        if (!rst_n)
            va_q <= '0;
        else if (accept)
            va_q <= req_va;
    end

    ptw_root_reg #(.AW(AW), .OFF_W(OFF_W)) root_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (root_wr_en),
        .wr_data   (root_wr_data),
        .capture   (accept),
        .root_snap (root_snap)
    );

    ptw_addr_gen #(.IDX_W(IDX_W)) addr_i (
        .root     (root_snap),
        .va       (va_q),
        .pde      (pde_q),
        .pte      (pte_q),
        .dir_addr (dir_addr),
        .tbl_addr (tbl_addr),
        .pa_small (pa_small),
        .pa_large (pa_large)
    );

    ptw_fsm #(.AW(AW)) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .accept        (accept),
        .busy          (busy),
        .mem_req_valid (mem_req_valid),
        .use_tbl       (use_tbl),
        .pde_q         (pde_q),
        .pte_q         (pte_q),
        .rsp_valid     (rsp_valid),
        .rsp_fault     (rsp_fault),
        .rsp_large     (rsp_large),
        .rsp_wr        (rsp_writable),
        .rsp_usr       (rsp_user)
    );

    assign mem_req_addr = use_tbl ? tbl_addr : dir_addr;

    always_comb begin
        rsp_pa = '0;
        if (rsp_valid && !rsp_fault)
            rsp_pa = rsp_large ? pa_large : pa_small;
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R7
    fault_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_pa == '0));
endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        root_wr_en = 1'b0;
    logic [31:0] root_wr_data = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic        busy, rsp_valid, rsp_fault, rsp_large, rsp_writable, rsp_user;
    logic [31:0] rsp_pa;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_req_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int n_chk = 0;
    int n_bad = 0;
    int rd_cnt = 0;
    logic [31:0] rd_addr [4];
    logic [31:0] mem [logic [31:0]];
    logic [31:0] base_model = '0;

    always #5 clk = ~clk;

    pt_walker dut_i (
        .clk(clk), .rst_n(rst_n),
        .root_wr_en(root_wr_en), .root_wr_data(root_wr_data),
        .req_valid(req_valid), .req_va(req_va), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
        .rsp_large(rsp_large), .rsp_writable(rsp_writable), .rsp_user(rsp_user),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [31:0] lookup(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Memory model: random ready, random response latency.
    initial begin
        logic [31:0] a;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_req_ready = ($urandom % 3) != 0;
            if (mem_req_valid && mem_req_ready) begin
                a = mem_req_addr;
                rd_addr[rd_cnt % 4] = a;
                rd_cnt++;
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat ($urandom % 3) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = lookup(a);
            end
        end
    end

    function automatic logic [31:0] dir_of(input logic [31:0] base, input logic [31:0] va);
        return {base[31:12], va[31:22], 2'b00};
    endfunction

    function automatic logic [31:0] tbl_of(input logic [31:0] pde, input logic [31:0] va);
        return {pde[31:12], va[21:12], 2'b00};
    endfunction

    task automatic load(input logic [31:0] va, input logic [31:0] pde, input logic [31:0] pte);
        mem.delete();
        mem[dir_of(base_model, va)] = pde;
        if (pde[0] && !pde[7])
            mem[tbl_of(pde, va)] = pte;
    endtask

    task automatic set_root(input logic [31:0] r);
        @(negedge clk);
        root_wr_en = 1'b1;
        root_wr_data = r;
        @(negedge clk);
        root_wr_en = 1'b0;
        base_model = r;
    endtask

    task automatic run_walk(input logic [31:0] va, input bit hold_req, input bit wr_mid, input logic [31:0] new_root);
        logic [31:0] a0, a1, pde, pte, e_pa;
        bit e_f, e_l, e_w, e_u;
        int e_n, n;
        a0 = dir_of(base_model, va);
        pde = lookup(a0);
        a1 = tbl_of(pde, va);
        pte = lookup(a1);
        e_pa = '0; e_f = 0; e_l = 0; e_w = 0; e_u = 0;
        if (!pde[0]) begin
            e_n = 1; e_f = 1;
        end else if (pde[7]) begin
            e_n = 1; e_l = 1; e_pa = {pde[31:22], va[21:0]}; e_w = pde[1]; e_u = pde[2];
        end else begin
            e_n = 2;
            if (!pte[0]) e_f = 1;
            else begin
                e_pa = {pte[31:12], va[11:0]}; e_w = pde[1] & pte[1]; e_u = pde[2] & pte[2];
            end
        end
        @(negedge clk);
        rd_cnt = 0;
        req_valid = 1'b1;
        req_va = va;
        @(negedge clk);
        chk("R10", "busy after accept", {31'b0, busy}, 32'd1);
        if (hold_req) req_va = ~va;
        else req_valid = 1'b0;
        if (wr_mid) begin
            root_wr_en = 1'b1;
            root_wr_data = new_root;
            @(negedge clk);
            root_wr_en = 1'b0;
        end
        n = 0;
        while (!rsp_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        chk("R11", "response seen", {31'b0, rsp_valid}, 32'd1);
        chk(wr_mid ? "R12" : "R2", "directory address", rd_addr[0], a0);
        if (e_n == 2) chk("R3", "table address", rd_addr[1], a1);
        chk("R9", "read count", rd_cnt, e_n);
        chk(e_f ? (e_n == 1 ? "R6" : "R7") : "R4", "fault", {31'b0, rsp_fault}, {31'b0, e_f});
        chk(e_l ? "R5" : "R4", "pa", rsp_pa, e_pa);
        chk("R5", "large flag", {31'b0, rsp_large}, {31'b0, e_l});
        chk("R8", "writable", {31'b0, rsp_writable}, {31'b0, e_w});
        chk("R8", "user", {31'b0, rsp_user}, {31'b0, e_u});
        @(negedge clk);
        chk("R11", "idle after response", {30'b0, rsp_valid, busy}, 32'd0);
        if (hold_req) begin
            @(negedge clk);
            chk("R10", "held request ignored", {30'b0, busy, mem_req_valid}, 32'd0);
            chk("R10", "no extra reads", rd_cnt, e_n);
        end
        if (wr_mid) base_model = new_root;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] va, pde, pte;
        int k;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1", "reset outputs", {29'b0, busy, rsp_valid, mem_req_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "outputs after reset", {29'b0, busy, rsp_valid, mem_req_valid}, 32'd0);

        // R1: root is 0 after reset, so the first walk reads from page 0
        load(32'hABC1_2345, 32'h0040_5007, 32'h1234_5007);
        run_walk(32'hABC1_2345, 0, 0, 0);

        set_root(32'h0010_0FFF);
        base_model = 32'h0010_0000;
        // R5: large page
        load(32'hFFC0_0001, 32'h8880_0087, 0);
        run_walk(32'hFFC0_0001, 0, 0, 0);
        // R6: directory not present
        load(32'h1234_5678, 32'h0000_3006, 0);
        run_walk(32'h1234_5678, 0, 0, 0);
        // R7: table not present
        load(32'h0000_1FFF, 32'h0000_7007, 32'hFFFF_F006);
        run_walk(32'h0000_1FFF, 0, 0, 0);
        // R8: mixed permissions
        load(32'h7FFF_FFFF, 32'h0002_0003, 32'hCAFE_B005);
        run_walk(32'h7FFF_FFFF, 0, 0, 0);
        // R10: request held high while busy
        load(32'h4000_0123, 32'h0050_0001, 32'h0BAD_0007);
        run_walk(32'h4000_0123, 1, 0, 0);
        // R12: root written mid-walk
        load(32'h0800_0400, 32'h0060_0007, 32'h0777_7003);
        run_walk(32'h0800_0400, 0, 1, 32'h0020_0000);
        load(32'h0800_0400, 32'h0061_0087, 0);
        run_walk(32'h0800_0400, 0, 0, 0);

        for (int i = 0; i < 300; i++) begin
            if (i % 50 == 0) set_root($urandom & 32'hFFFF_F000);
            va = $urandom;
            pde = $urandom;
            pte = $urandom;
            k = $urandom % 8;
            if (k == 0) pde[0] = 1'b0;
            else if (k < 3) begin pde[0] = 1'b1; pde[7] = 1'b1; end
            else begin pde[0] = 1'b1; pde[7] = 1'b0; end
            pte[0] = ($urandom % 5) != 0;
            if (tbl_of(pde, va) == dir_of(base_model, va)) pde[12] = ~pde[12];
            load(va, pde, pte);
            run_walk(va, ($urandom % 10) == 0, ($urandom % 10) == 0, $urandom & 32'hFFFF_F000);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule